// File: doc/BRIEF.md
# Sample Output Demultiplexer and Formatter

This block sits between a converter core, which produces one result per rising edge of the sample clock, and two result ports, A and B. In demultiplex mode it halves the sample clock. It gathers each pair of consecutive results and presents them side by side on the two ports. Both ports change together, so downstream logic can capture at half the sample rate. In straight mode it forwards every result to both ports at the full rate, and its clock output is the inverse of the sample clock.

The halved clock has a synchronous active-low restart input. Several converters that share the sample clock and this restart signal come out of it with the same output phase. Each port can be switched off on its own, and a polarity control flips every data bit. A power-save input freezes all internal state and parks the clock output low.

Top module: `adc_demux_fmt`

## Requirements
- R1: `mode_dmx_i` high selects demultiplex mode. Low selects straight mode, in which both port registers load on every rising edge of `clk_i`.
- R2: In straight mode, a result presented at rising edge k appears on both ports after rising edge k+1, so the latency is two clocks.
- R3: In straight mode, `clk_out_o` is the logical inverse of `clk_i`.
- R4: In demultiplex mode, samples are numbered from 0, starting at the first edge at which the restart input is sampled high. Sample 2m goes to port B and sample 2m+1 goes to port A. Both appear together after edge 2m+3 and hold for two clock periods.
- R5: In demultiplex mode, `clk_out_o` is the halved clock. It goes high after edge 0, 2, 4, and so on, and low after the odd edges. It therefore rises one full input period after the ports change and falls together with the change.
- R6: `div_rst_ni` is sampled on the rising edge of `clk_i`. After every edge at which it is sampled low, the halved clock is low, so holding it low longer lengthens the restart.
- R7: The first edge at which `div_rst_ni` is sampled high drives the halved clock high, which gives a fixed phase from that edge onward.
- R8: `port_sel_i` encodes the port enables. 2'b00 enables only B, 2'b01 enables only A, and 2'b10 or 2'b11 (the unconnected setting) enables both. Each port's enable output reflects this at once.
- R9: A port whose enable is low drives all-zero data, which stands in for the high-impedance state.
- R10: `invert_i` high inverts all data bits of every enabled port, with no clock delay.
- R11: While `pwr_save_ni` is sampled low, no internal register changes, and `clk_out_o` is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Sample clock |
| div_rst_ni | input | 1 | Synchronous active-low restart of the halved clock |
| mode_dmx_i | input | 1 | 1 = demultiplex, 0 = straight |
| port_sel_i | input | 2 | Port enable code |
| invert_i | input | 1 | Invert output data bits |
| pwr_save_ni | input | 1 | Active-low power save |
| sample_i | input | 8 | Conversion result, one per clock |
| port_a_o | output | 8 | Port A data |
| port_a_oe_o | output | 1 | Port A drive enable |
| port_b_o | output | 8 | Port B data |
| port_b_oe_o | output | 1 | Port B drive enable |
| clk_out_o | output | 1 | Halved or inverted output clock |

## Verification
The properties assume that the mode input only changes while the restart input is low, or while the run is not being checked. They also assume that the restart and power-save inputs are stable around each rising edge. The stimulus applies every control change and every new result at the falling edge, half a period away from the capturing edge. After each mode change, it holds the restart input low for at least one edge before any phase or pairing is judged. Power save is only exercised in straight mode, so the demultiplex phase checks never see a frozen divider.

// File: rtl/adc_fmt_pkg.sv
package adc_fmt_pkg;

   // port enable codes; the two "both" codes include the unconnected setting
   typedef enum logic [1:0] {
      SEL_B_ONLY   = 2'b00,
      SEL_A_ONLY   = 2'b01,
      SEL_BOTH     = 2'b10,
      SEL_BOTH_ALT = 2'b11
   } port_sel_e;

   localparam int unsigned NUM_PORTS = 2;
   localparam int unsigned IDX_A     = 0;
   localparam int unsigned IDX_B     = 1;

   // bit IDX_A = port A enable, bit IDX_B = port B enable
   function automatic logic [NUM_PORTS-1:0] port_enables(input logic [1:0] sel);
      logic [NUM_PORTS-1:0] en;
      en = '1;
      case (port_sel_e'(sel))
         SEL_B_ONLY: en[IDX_A] = 1'b0;
         SEL_A_ONLY: en[IDX_B] = 1'b0;
         default:    en = '1;
      endcase
      return en;
   endfunction

endpackage

// File: rtl/adc_clk_div.sv
module adc_clk_div (
   input  logic clk_i,
   input  logic run_i,
   input  logic rst_ni,
   output logic half_o
);

   logic half_q;

   always_ff @(posedge clk_i) begin
      if (run_i) begin
         half_q <= rst_ni ? ~half_q : 1'b0;
      end
   end

   assign half_o = half_q;

endmodule

// File: rtl/adc_pair_pipe.sv
module adc_pair_pipe #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              run_i,
   input  logic              dmx_i,
   input  logic              phase_i,
   input  logic [DATA_W-1:0] sample_i,
   output logic [DATA_W-1:0] out_a_o,
   output logic [DATA_W-1:0] out_b_o
);

   logic [DATA_W-1:0] cap_q;
   logic [DATA_W-1:0] even_q;
   logic [DATA_W-1:0] pair_a_q;
   logic [DATA_W-1:0] pair_b_q;
   logic [DATA_W-1:0] out_a_q;
   logic [DATA_W-1:0] out_b_q;

   // capture stage and pairing stages
   always_ff @(posedge clk_i) begin
      if (run_i) begin
         cap_q <= sample_i;
         if (phase_i) begin
            even_q <= cap_q;
         end else begin
            pair_a_q <= cap_q;
            pair_b_q <= even_q;
         end
      end
   end

   // output stage: every clock in straight mode, on the falling half-clock edge in demux mode
   always_ff @(posedge clk_i) begin
      if (run_i) begin
         if (!dmx_i) begin
            out_a_q <= cap_q;
            out_b_q <= cap_q;
         end else if (phase_i) begin
            out_a_q <= pair_a_q;
            out_b_q <= pair_b_q;
         end
      end
   end

   assign out_a_o = out_a_q;
   assign out_b_o = out_b_q;

endmodule

// File: rtl/adc_port_drv.sv
module adc_port_drv #(
   parameter int unsigned DATA_W = 8
) (
   input  logic [DATA_W-1:0] data_i,
   input  logic              en_i,
   input  logic              inv_i,
   output logic [DATA_W-1:0] data_o,
   output logic              oe_o
);

   localparam logic [DATA_W-1:0] ZERO = '0;

   always_comb begin
      oe_o   = en_i;
      data_o = en_i ? (data_i ^ {DATA_W{inv_i}}) : ZERO;
   end

endmodule

// File: rtl/adc_demux_fmt.sv
module adc_demux_fmt #(
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              div_rst_ni,
   input  logic              mode_dmx_i,
   input  logic [1:0]        port_sel_i,
   input  logic              invert_i,
   input  logic              pwr_save_ni,
   input  logic [DATA_W-1:0] sample_i,
   output logic [DATA_W-1:0] port_a_o,
   output logic              port_a_oe_o,
   output logic [DATA_W-1:0] port_b_o,
   output logic              port_b_oe_o,
   output logic              clk_out_o
);

   import adc_fmt_pkg::*;

   if (DATA_W < 1) begin : g_bad_width
      $error("adc_demux_fmt: DATA_W must be at least 1");
   end

   logic                 half_clk;
   logic [DATA_W-1:0]    raw_a;
   logic [DATA_W-1:0]    raw_b;
   logic [NUM_PORTS-1:0] port_en;
   logic [DATA_W-1:0]    lane_raw [NUM_PORTS];
   logic [DATA_W-1:0]    lane_out [NUM_PORTS];
   logic [NUM_PORTS-1:0] lane_oe;

   adc_clk_div u_div (
      .clk_i  (clk_i),
      .run_i  (pwr_save_ni),
      .rst_ni (div_rst_ni),
      .half_o (half_clk)
   );

   adc_pair_pipe #(.DATA_W(DATA_W)) u_pipe (
      .clk_i    (clk_i),
      .run_i    (pwr_save_ni),
      .dmx_i    (mode_dmx_i),
      .phase_i  (half_clk),
      .sample_i (sample_i),
      .out_a_o  (raw_a),
      .out_b_o  (raw_b)
   );

   assign port_en        = port_enables(port_sel_i);
   assign lane_raw[IDX_A] = raw_a;
   assign lane_raw[IDX_B] = raw_b;

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_lane
      adc_port_drv #(.DATA_W(DATA_W)) u_drv (
         .data_i (lane_raw[p]),
         .en_i   (port_en[p]),
         .inv_i  (invert_i),
         .data_o (lane_out[p]),
         .oe_o   (lane_oe[p])
      );
   end

   assign port_a_o    = lane_out[IDX_A];
   assign port_b_o    = lane_out[IDX_B];
   assign port_a_oe_o = lane_oe[IDX_A];
   assign port_b_oe_o = lane_oe[IDX_B];

   assign clk_out_o = pwr_save_ni & (mode_dmx_i ? half_clk : ~clk_i);

endmodule

// File: rtl/adc_demux_fmt_chk.sv
module adc_demux_fmt_chk #(
   parameter int unsigned DATA_W = 8
) (
   input logic              clk_i,
   input logic              div_rst_ni,
   input logic              mode_dmx_i,
   input logic [1:0]        port_sel_i,
   input logic              pwr_save_ni,
   input logic [DATA_W-1:0] raw_a,
   input logic [DATA_W-1:0] raw_b,
   input logic [DATA_W-1:0] port_a_o,
   input logic [DATA_W-1:0] port_b_o,
   input logic              port_a_oe_o,
   input logic              port_b_oe_o,
   input logic              clk_out_o
);

   // R6
   restart_low_chk: assert property (@(posedge clk_i) disable iff (!pwr_save_ni)
      (mode_dmx_i && !div_rst_ni) |=> (!mode_dmx_i || !clk_out_o));

   // R5
   half_toggle_chk: assert property (@(posedge clk_i) disable iff (!pwr_save_ni)
      (mode_dmx_i && div_rst_ni) |=> (!mode_dmx_i || (clk_out_o != $past(clk_out_o))));

   // R4
   pair_hold_chk: assert property (@(posedge clk_i) disable iff (!pwr_save_ni)
      (mode_dmx_i && !clk_out_o) |=> ($stable(raw_a) && $stable(raw_b)));

   // R11
   freeze_chk: assert property (@(posedge clk_i) disable iff (!div_rst_ni && mode_dmx_i)
      (!pwr_save_ni) |=> ($stable(raw_a) && $stable(raw_b)));

   // R8
   always_comb begin
      if (port_sel_i == 2'b00) begin
         sel_b_only_chk: assert (!port_a_oe_o && port_b_oe_o);
      end
      if (port_sel_i == 2'b01) begin
         sel_a_only_chk: assert (port_a_oe_o && !port_b_oe_o);
      end
   end

   // R9
   always_comb begin
      if (!port_a_oe_o) begin
         idle_a_zero_chk: assert (port_a_o == '0);
      end
      if (!port_b_oe_o) begin
         idle_b_zero_chk: assert (port_b_o == '0);
      end
   end

endmodule

bind adc_demux_fmt adc_demux_fmt_chk #(.DATA_W(DATA_W)) u_chk (
   .clk_i       (clk_i),
   .div_rst_ni  (div_rst_ni),
   .mode_dmx_i  (mode_dmx_i),
   .port_sel_i  (port_sel_i),
   .pwr_save_ni (pwr_save_ni),
   .raw_a       (raw_a),
   .raw_b       (raw_b),
   .port_a_o    (port_a_o),
   .port_b_o    (port_b_o),
   .port_a_oe_o (port_a_oe_o),
   .port_b_oe_o (port_b_oe_o),
   .clk_out_o   (clk_out_o)
);

// File: tb/sim_adc_demux_fmt.sv
module sim_adc_demux_fmt;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mode = 1'b1;
   logic [1:0] sel = 2'b10;
   logic       inv = 1'b0;
   logic       pwr_n = 1'b1;
   logic [7:0] smp = 8'h00;
   logic [7:0] pa, pb;
   logic       pa_oe, pb_oe, ck_out;

   int nchk = 0;
   int nerr = 0;
   bit done = 0;
   logic [7:0] dd [0:63];

   always #2 clk = ~clk;

   adc_demux_fmt u0 (
      .clk_i       (clk),
      .div_rst_ni  (rst_n),
      .mode_dmx_i  (mode),
      .port_sel_i  (sel),
      .invert_i    (inv),
      .pwr_save_ni (pwr_n),
      .sample_i    (smp),
      .port_a_o    (pa),
      .port_a_oe_o (pa_oe),
      .port_b_o    (pb),
      .port_b_oe_o (pb_oe),
      .clk_out_o   (ck_out)
   );

   task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   function automatic logic [7:0] drive_of(input bit oe, input bit iv, input logic [7:0] v);
      return oe ? (v ^ {8{iv}}) : 8'h00;
   endfunction

   // check both ports against expected raw values under the current sel/inv
   task automatic chk_ports(input string req, input logic [7:0] ea, input logic [7:0] eb);
      bit oa, ob;
      oa = (sel != 2'b00);
      ob = (sel != 2'b01);
      chk("R8 oe A", {7'd0, pa_oe}, {7'd0, oa});
      chk("R8 oe B", {7'd0, pb_oe}, {7'd0, ob});
      chk({req, " A (R9/R10)"}, pa, drive_of(oa, inv, ea));
      chk({req, " B (R9/R10)"}, pb, drive_of(ob, inv, eb));
   endtask

   task automatic run_demux(input int rst_len, input int n, input int seed);
      mode = 1'b1;
      pwr_n = 1'b1;
      for (int i = 0; i < rst_len; i++) begin
         @(negedge clk);
         if (i >= 1) chk("R6 restart holds clock low", {7'd0, ck_out}, 8'd0);
         rst_n = 1'b0;
         smp = 8'(i * 13 + seed);
      end
      for (int t = 0; t <= n; t++) begin
         @(negedge clk);
         rst_n = 1'b1;
         sel = 2'(t);
         inv = ((t / 4) % 2) == 1;
         #1;
         if (t == 1) chk("R7 first high edge raises clock", {7'd0, ck_out}, 8'd1);
         else if (t >= 2) chk("R5 halved clock phase", {7'd0, ck_out}, {7'd0, ((t - 1) % 2) == 0});
         if (t >= 4) begin
            int p;
            p = (t - 4) / 2;
            chk_ports("R4 pair", dd[2 * p + 1], dd[2 * p]);
         end
         dd[t] = 8'(t * 37 + seed * 5 + 3);
         smp = dd[t];
      end
   endtask

   task automatic run_straight(input int n, input int seed);
      mode = 1'b0;
      pwr_n = 1'b1;
      rst_n = 1'b1;
      for (int t = 0; t <= n; t++) begin
         @(negedge clk);
         sel = 2'(t + 1);
         inv = ((t / 4) % 2) == 0;
         #1;
         chk("R3 inverted clock while clk low", {7'd0, ck_out}, 8'd1);
         if (t >= 2) chk_ports("R1/R2 straight", dd[t - 2], dd[t - 2]);
         dd[t] = 8'(t * 53 + seed);
         smp = dd[t];
      end
      @(posedge clk);
      #1;
      chk("R3 inverted clock while clk high", {7'd0, ck_out}, 8'd0);
   endtask

   task automatic summary;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         nchk++;
         nerr++;
         $display("FAIL watchdog actual=running expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      logic [7:0] held_a, held_b;
      run_demux(3, 40, 1);
      run_straight(30, 7);
      // R11: power save in straight mode
      @(negedge clk);
      sel = 2'b10;
      inv = 1'b0;
      #1;
      held_a = pa;
      held_b = pb;
      pwr_n = 1'b0;
      for (int i = 0; i < 4; i++) begin
         smp = 8'(i * 91 + 5);
         @(negedge clk);
         #1;
         chk("R11 clock low in power save", {7'd0, ck_out}, 8'd0);
         chk("R11 port A frozen", pa, held_a);
         chk("R11 port B frozen", pb, held_b);
      end
      pwr_n = 1'b1;
      // restart with a longer restart pulse and a new phase
      run_demux(6, 24, 9);
      run_straight(8, 3);
      run_demux(2, 12, 4);
      done = 1;
      summary();
      $finish;
   end

endmodule